// File: doc/BRIEF.md
# Priority Lane Selector with One-Hot Index Output

This block chooses one lane out of a request vector by fixed priority and turns a small index field carried by that lane into a one-hot word. It has no clock and no state: the output follows the inputs within the same cycle.

Each lane owns a slot of `STRIDE` bits in a flat input bus, and only `log2(OUT_W)` of those bits, starting at bit `FIELD_LO` of the slot, are used as the lane's index. The winning lane's index selects the single output bit that is set. When no lane requests, the output is all zero. A parameter reverses the priority so that the highest-numbered active lane wins.

Internally the block does not use a ripple leading-one scan. The lanes become (valid, index) records, and a balanced binary merge tree reduces them in logarithmic depth. A doubling decoder, gated by the root valid, then expands the surviving index.

Top module: `prio_onehot_scatter`

## Requirements
- R1: Lane k's index field is `lanes_i[k*STRIDE+FIELD_LO +: log2(OUT_W)]`. Every other bit of the lane bus has no effect on the output.
- R2: With `HIGH_FIRST=0`, the lane that wins is the lowest-numbered lane k with `req_i[k]=1`.
- R3: When `req_i` is all zero, `onehot_o` is all zero.
- R4: Whenever at least one request bit is set, exactly one bit of `onehot_o` is set.
- R5: The set output bit is the one whose position equals the winning lane's index field. The fields of lanes that do not win have no effect; the output is never an OR of several decoded fields.
- R6: With `HIGH_FIRST=1`, the lane that wins is the highest-numbered lane k with `req_i[k]=1`.
- R7: The block is purely combinational. A change on the inputs appears on `onehot_o` with no clock edge in between.
- R8: The lane count is independent of the output width. For example, 8 lanes with a 6-bit stride and a field at bits 5:2 drive a 16-bit output correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | LANES | Request bit per lane |
| lanes_i | input | LANES*STRIDE | Flat lane bus; lane k occupies bits k*STRIDE upward |
| onehot_o | output | OUT_W | One-hot index of the winning lane, or zero |

## Verification
A faulty merge node hands the index of a lower-priority lane upward. At the ports this shows up at once, on the same input vector, as a wrong bit position whenever two or more lanes request with different fields; pair and prefix/suffix masks are aimed at that case. A fault in the decoder or in the valid gating shows up as two bits set, or as a bit set while all requests are low, and is visible in the same cycle. Field extraction faults are exposed by single-lane vectors with random filler in the bits outside the field.

// File: rtl/prio_onehot_pkg.sv
package prio_onehot_pkg;
   localparam int unsigned LANES_MIN = 4;
   localparam int unsigned LANES_MAX = 64;

   // smallest power of two not below n
   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned p;
      p = 1;
      while (p < n) p = p << 1;
      return p;
   endfunction
endpackage

// File: rtl/prio_lane_unpack.sv
module prio_lane_unpack
   import prio_onehot_pkg::*;
#(
   parameter int unsigned LANES      = 16,
   parameter int unsigned STRIDE     = 5,
   parameter int unsigned FIELD_LO   = 1,
   parameter int unsigned IDX_W      = 4,
   parameter bit          HIGH_FIRST = 1'b0
) (
   input  logic [LANES-1:0]        req_i,
   input  logic [LANES*STRIDE-1:0] lanes_i,
   output logic [LANES-1:0]        leaf_v_o,
   output logic [LANES*IDX_W-1:0]  leaf_idx_o
);
   // Leaf 0 is always the highest-priority lane.
   for (genvar k = 0; k < LANES; k++) begin : g_leaf
      localparam int unsigned SRC = HIGH_FIRST ? (LANES - 1 - k) : k;
      if (HIGH_FIRST) begin : g_rev
         assign leaf_v_o[k] = req_i[SRC];
         assign leaf_idx_o[k*IDX_W +: IDX_W] = lanes_i[SRC*STRIDE + FIELD_LO +: IDX_W];
      end else begin : g_fwd
         assign leaf_v_o[k] = req_i[k];
         assign leaf_idx_o[k*IDX_W +: IDX_W] = lanes_i[k*STRIDE + FIELD_LO +: IDX_W];
      end
   end
endmodule

// File: rtl/prio_merge_node.sv
module prio_merge_node #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             hi_v_i,
   input  logic [IDX_W-1:0] hi_idx_i,
   input  logic             lo_v_i,
   input  logic [IDX_W-1:0] lo_idx_i,
   output logic             v_o,
   output logic [IDX_W-1:0] idx_o
);
   logic pick_lo;
   assign pick_lo = ~hi_v_i & lo_v_i;
   assign v_o     = hi_v_i | lo_v_i;
   assign idx_o   = pick_lo ? lo_idx_i : hi_idx_i;
endmodule

// File: rtl/prio_merge_tree.sv
module prio_merge_tree
   import prio_onehot_pkg::*;
#(
   parameter int unsigned LANES = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [LANES-1:0]       leaf_v_i,
   input  logic [LANES*IDX_W-1:0] leaf_idx_i,
   output logic                   root_v_o,
   output logic [IDX_W-1:0]       root_idx_o
);
   localparam int unsigned SLOTS = pow2_ceil(LANES);
   localparam int unsigned NODES = 2 * SLOTS;

   // heap layout: node n has children 2n (higher priority) and 2n+1
   logic [NODES-1:1] node_v;
   logic [IDX_W-1:0] node_idx [NODES-1:1];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < LANES) begin : g_real
         assign node_v[SLOTS + s]   = leaf_v_i[s];
         assign node_idx[SLOTS + s] = leaf_idx_i[s*IDX_W +: IDX_W];
      end else begin : g_pad
         assign node_v[SLOTS + s]   = 1'b0;
         assign node_idx[SLOTS + s] = '0;
      end
   end

   for (genvar n = 1; n < SLOTS; n++) begin : g_node
      prio_merge_node #(.IDX_W(IDX_W)) u_node (
         .hi_v_i   (node_v[2*n]),
         .hi_idx_i (node_idx[2*n]),
         .lo_v_i   (node_v[2*n+1]),
         .lo_idx_i (node_idx[2*n+1]),
         .v_o      (node_v[n]),
         .idx_o    (node_idx[n])
      );
   end

   assign root_v_o   = node_v[1];
   assign root_idx_o = node_idx[1];
endmodule

// File: rtl/prio_onehot_decode.sv
module prio_onehot_decode #(
   parameter int unsigned OUT_W = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic             en_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [OUT_W-1:0] onehot_o
);
   // stage b holds 2**b gated terms in its low bits
   logic [IDX_W:0][OUT_W-1:0] stage;

   assign stage[0][0] = en_i;
   for (genvar g = 1; g < OUT_W; g++) begin : g_s0_zero
      assign stage[0][g] = 1'b0;
   end

   for (genvar b = 0; b < IDX_W; b++) begin : g_stage
      localparam int unsigned HALF = 1 << b;
      for (genvar g = 0; g < HALF; g++) begin : g_term
         assign stage[b+1][g]        = stage[b][g] & ~idx_i[b];
         assign stage[b+1][g + HALF] = stage[b][g] &  idx_i[b];
      end
      for (genvar g = 2*HALF; g < OUT_W; g++) begin : g_zero
         assign stage[b+1][g] = 1'b0;
      end
   end

   assign onehot_o = stage[IDX_W];
endmodule

// File: rtl/prio_onehot_scatter.sv
module prio_onehot_scatter
   import prio_onehot_pkg::*;
#(
   parameter int unsigned LANES      = 16,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned STRIDE     = 5,
   parameter int unsigned FIELD_LO   = 1,
   parameter bit          HIGH_FIRST = 1'b0
) (
   input  logic [LANES-1:0]        req_i,
   input  logic [LANES*STRIDE-1:0] lanes_i,
   output logic [OUT_W-1:0]        onehot_o
);
   localparam int unsigned IDX_W = $clog2(OUT_W);

   if (OUT_W < 2 || (1 << IDX_W) != OUT_W) begin : g_bad_width
      $error("prio_onehot_scatter: OUT_W must be a power of two of at least 2");
   end
   if (LANES < LANES_MIN || LANES > LANES_MAX) begin : g_bad_lanes
      $error("prio_onehot_scatter: LANES outside supported range");
   end
   if (FIELD_LO + IDX_W > STRIDE) begin : g_bad_field
      $error("prio_onehot_scatter: index field does not fit in a lane slot");
   end

   logic [LANES-1:0]       leaf_v;
   logic [LANES*IDX_W-1:0] leaf_idx;
   logic                   root_v;
   logic [IDX_W-1:0]       root_idx;

   prio_lane_unpack #(
      .LANES(LANES), .STRIDE(STRIDE), .FIELD_LO(FIELD_LO),
      .IDX_W(IDX_W), .HIGH_FIRST(HIGH_FIRST)
   ) u_unpack (
      .req_i      (req_i),
      .lanes_i    (lanes_i),
      .leaf_v_o   (leaf_v),
      .leaf_idx_o (leaf_idx)
   );

   prio_merge_tree #(.LANES(LANES), .IDX_W(IDX_W)) u_tree (
      .leaf_v_i   (leaf_v),
      .leaf_idx_i (leaf_idx),
      .root_v_o   (root_v),
      .root_idx_o (root_idx)
   );

   prio_onehot_decode #(.OUT_W(OUT_W), .IDX_W(IDX_W)) u_dec (
      .en_i     (root_v),
      .idx_i    (root_idx),
      .onehot_o (onehot_o)
   );
endmodule

// File: rtl/prio_onehot_scatter_chk.sv
module prio_onehot_scatter_chk #(
   parameter int unsigned LANES      = 16,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned STRIDE     = 5,
   parameter int unsigned FIELD_LO   = 1,
   parameter bit          HIGH_FIRST = 1'b0
) (
   input logic [LANES-1:0]        req_i,
   input logic [LANES*STRIDE-1:0] lanes_i,
   input logic [OUT_W-1:0]        onehot_o
);
   localparam int unsigned IDX_W = $clog2(OUT_W);

   logic             seen;
   logic [IDX_W-1:0] seen_field;

   always_comb begin
      seen       = 1'b0;
      seen_field = '0;
      for (int j = 0; j < LANES; j++) begin
         if (!seen && req_i[HIGH_FIRST ? (LANES-1-j) : j]) begin
            seen       = 1'b1;
            seen_field = lanes_i[(HIGH_FIRST ? (LANES-1-j) : j)*STRIDE + FIELD_LO +: IDX_W];
         end
      end
   end

   always_comb begin
      a_r3_idle_zero: assert ((|req_i) || (onehot_o == '0))
         else $error("R3: output set with no request");
      a_r4_single_hot: assert (!(|req_i) || ($countones(onehot_o) == 1))
         else $error("R4: output not one-hot");
      a_r5_winner_field: assert (!seen || onehot_o[seen_field])
         else $error("R5: winner field bit not set");
      if ($countones(req_i) == 1) begin
         a_r1_lone_lane: assert ($countones(onehot_o) == 1 && onehot_o[seen_field])
            else $error("R1: lone lane field not routed");
      end
   end
endmodule

bind prio_onehot_scatter prio_onehot_scatter_chk #(
   .LANES(LANES), .OUT_W(OUT_W), .STRIDE(STRIDE),
   .FIELD_LO(FIELD_LO), .HIGH_FIRST(HIGH_FIRST)
) u_chk (
   .req_i    (req_i),
   .lanes_i  (lanes_i),
   .onehot_o (onehot_o)
);

// File: tb/tb_prio_onehot_scatter.sv
module tb_prio_onehot_scatter;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int bad    = 0;
   bit finished = 1'b0;

   // A: 16 lanes, stride 5, field 4:1, lowest wins
   logic [15:0] req_a;
   logic [79:0] lanes_a;
   logic [15:0] oh_a;
   // B: 8 lanes, stride 6, field 5:2, highest wins, 16 outputs
   logic [7:0]  req_b;
   logic [47:0] lanes_b;
   logic [15:0] oh_b;

   prio_onehot_scatter #(.LANES(16), .OUT_W(16), .STRIDE(5), .FIELD_LO(1), .HIGH_FIRST(1'b0))
   dut (.req_i(req_a), .lanes_i(lanes_a), .onehot_o(oh_a));

   prio_onehot_scatter #(.LANES(8), .OUT_W(16), .STRIDE(6), .FIELD_LO(2), .HIGH_FIRST(1'b1))
   dut_b (.req_i(req_b), .lanes_i(lanes_b), .onehot_o(oh_b));

   function automatic logic [15:0] ref_a(input logic [15:0] r, input logic [79:0] l);
      for (int k = 0; k < 16; k++)
         if (r[k]) return 16'(1) << l[k*5+1 +: 4];
      return 16'h0;
   endfunction

   function automatic logic [15:0] ref_b(input logic [7:0] r, input logic [47:0] l);
      for (int k = 7; k >= 0; k--)
         if (r[k]) return 16'(1) << l[k*6+2 +: 4];
      return 16'h0;
   endfunction

   task automatic cmp_a(input string tag);
      logic [15:0] e;
      e = ref_a(req_a, lanes_a);
      checks++;
      if (oh_a !== e) begin
         bad++;
         $display("FAIL %s dut req=%h got=%h exp=%h", tag, req_a, oh_a, e);
      end
   endtask

   task automatic cmp_b(input string tag);
      logic [15:0] e;
      e = ref_b(req_b, lanes_b);
      checks++;
      if (oh_b !== e) begin
         bad++;
         $display("FAIL %s dut_b req=%h got=%h exp=%h", tag, req_b, oh_b, e);
      end
   endtask

   task automatic noise();
      for (int i = 0; i < 80; i++) lanes_a[i] = 1'($urandom());
      for (int i = 0; i < 48; i++) lanes_b[i] = 1'($urandom());
   endtask

   task automatic both(input string tag);
      @(negedge clk);
      cmp_a(tag);
      cmp_b(tag);
   endtask

   initial begin
      req_a = '0; lanes_a = '0; req_b = '0; lanes_b = '0;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      // R3: idle state after reset, then with noisy lanes
      both("R3");
      @(posedge clk); noise(); both("R3");

      // R7: input change seen without an intervening edge
      @(negedge clk);
      req_a = 16'h0010; lanes_a[4*5+1 +: 4] = 4'd9;
      #1;
      cmp_a("R7");
      checks++;
      if (oh_a !== 16'h0200) begin
         bad++;
         $display("FAIL R7 got=%h exp=%h", oh_a, 16'h0200);
      end

      // R1/R5: single lane, field value varies, filler random
      for (int k = 0; k < 16; k++) begin
         @(posedge clk);
         noise();
         req_a = 16'(1) << k;
         lanes_a[k*5+1 +: 4] = 4'(15 - k);
         req_b = 8'(1) << (k % 8);
         lanes_b[(k%8)*6+2 +: 4] = 4'(k);
         both("R1");
      end

      // R2 / R6 with all lanes active, two field patterns
      @(posedge clk);
      req_a = '1; req_b = '1;
      for (int k = 0; k < 16; k++) lanes_a[k*5+1 +: 4] = 4'(k);
      for (int k = 0; k < 8; k++)  lanes_b[k*6+2 +: 4] = 4'(k + 3);
      @(negedge clk); cmp_a("R2"); cmp_b("R6");
      checks++;
      if (oh_a !== 16'h0001) begin bad++; $display("FAIL R2 got=%h exp=%h", oh_a, 16'h0001); end
      checks++;
      if (oh_b !== 16'h0400) begin bad++; $display("FAIL R6 got=%h exp=%h", oh_b, 16'h0400); end
      @(posedge clk);
      for (int k = 0; k < 16; k++) lanes_a[k*5+1 +: 4] = 4'(15 - k);
      for (int k = 0; k < 8; k++)  lanes_b[k*6+2 +: 4] = 4'(7 - k);
      @(negedge clk); cmp_a("R2"); cmp_b("R6");

      // R2 prefix masks on A (winner k), R6 suffix masks on B (winner k)
      for (int k = 0; k < 16; k++) begin
         @(posedge clk);
         noise();
         req_a = 16'hFFFF << k;
         req_b = 8'hFF >> (7 - (k % 8));
         @(negedge clk); cmp_a("R2"); cmp_b("R6");
      end

      // R5: adjacent pairs with distinct fields; loser must not leak
      for (int i = 0; i < 15; i++) begin
         @(posedge clk);
         noise();
         req_a = (16'(1) << i) | (16'(1) << (i + 1));
         lanes_a[i*5+1 +: 4]     = 4'(i + 1);
         lanes_a[(i+1)*5+1 +: 4] = 4'(i + 6);
         req_b = (8'(1) << (i % 7)) | (8'(1) << ((i % 7) + 1));
         lanes_b[(i%7)*6+2 +: 4]     = 4'(i + 2);
         lanes_b[((i%7)+1)*6+2 +: 4] = 4'(i + 9);
         @(negedge clk); cmp_a("R5"); cmp_b("R8");
      end

      // R4/R8: random vectors
      for (int r = 0; r < 300; r++) begin
         @(posedge clk);
         noise();
         req_a = 16'($urandom()) & 16'($urandom());
         req_b = 8'($urandom()) & 8'($urandom());
         @(negedge clk); cmp_a("R4"); cmp_b("R8");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         checks++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule